// File: doc/BRIEF.md
# Frequency-Lock Integrator and Tap Modulator

This block is the digital half of a frequency-locked loop. It runs on the controlled oscillator's clock. It compares a slow reference clock with the oscillator clock after the oscillator clock has been divided down. A 10-bit saturating up/down integrator moves one step up for every reference period and one step down for every period of the divided oscillator. When the oscillator runs at D x (N+1) times the reference, the two rates balance and the integrator holds its value.

The upper five integrator bits choose one of 29 oscillator taps. Codes from 28 upward all mean the top tap. The lower five bits are a fraction k. A modulator uses k to mix the chosen tap with the next one up, so that the average frequency falls between two taps.

The block also produces a clock-enable for the system clock:
- With the output divider bypassed, the system clock runs at the full oscillator rate, D x (N+1) times the reference.
- Otherwise the enable fires once every D oscillator cycles, which gives (N+1) times the reference.

The default use is D = 2 (select code 1) with the divider not bypassed. The oscillator range select is passed to the oscillator through one register.

Every pin is a plain level control or status signal. No data streams through the block, so no valid/ready handshake applies.

Top module: `freq_lock_ctrl`

## Requirements
- R1: While rst_ni is low, the integrator reads 512, tap_o and mod_tap_o read 16, and band_o reads 0.
- R2: The divide factor is D = 2^div_sel_i, so codes 0,1,2,3 give D = 1,2,4,8. Counting from reset release, the integrator takes one down step at every clock edge whose number is a multiple of D x (mult_n_i+1).
- R3: Suppose ref_clk_i is sampled low at clock edge k-1 and high at edge k. The integrator then takes one up step at edge k+2. A steady high or low level causes no steps.
- R4: The integrator never wraps. An up step at 1023 leaves it at 1023, and a down step at 0 leaves it at 0.
- R5: An up step and a down step that fall on the same edge cancel, and the integrator keeps its value.
- R6: tap_o equals integ_o[9:5] when that value is 28 or less, and 28 otherwise.
- R7: Let k = integ_o[4:0] be held constant. In every 32 consecutive cycles, mod_tap_o equals tap_o+1 in exactly k cycles and equals tap_o in the others. When tap_o is 28, mod_tap_o stays at 28.
- R8: When k is a power of two, the cycles with the higher tap are spaced exactly 32/k cycles apart.
- R9: With out_div_en_i = 0, out_en_o is high in exactly one of every D cycles, on the cycles where the pre-divider completes. With out_div_en_i = 1, out_en_o is high in every cycle.
- R10: band_o takes the value of range_sel_i one clock edge after it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc_i | input | 1 | Controlled-oscillator clock, which clocks the whole block |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_clk_i | input | 1 | Reference clock level, asynchronous to clk_osc_i |
| div_sel_i | input | 2 | Pre-divider code; D = 2^code |
| mult_n_i | input | 7 | Multiplier N; the post-divider divides by N+1 |
| out_div_en_i | input | 1 | 1 bypasses the output divide-by-D |
| range_sel_i | input | 2 | Oscillator range select |
| tap_o | output | 5 | Selected oscillator tap, 0..28 |
| mod_tap_o | output | 5 | Tap applied this cycle: tap_o or tap_o+1 |
| integ_o | output | 10 | Frequency integrator value |
| out_en_o | output | 1 | System-clock enable |
| band_o | output | 2 | Registered range select |

## Verification
Random trials draw a fresh D, N, bypass setting and range for each run. Each trial applies a random reference waveform and compares the integrator, tap, modulated tap and enable with a cycle model in every cycle. Runs with steady references bring out the divide-by-D x (N+1) down rate. Dense reference toggling against a divide-by-one feedback forces coincident steps, which exposes any failure to cancel.

Directed runs cover the remaining cases:
- Both saturation ends, which tell clamping apart from wrap-around.
- Fractions of 1, 8, 13, 16 and 31, which separate an exact k-of-32 mix and even spacing from a mix that is biased or bunched.
- Enable counts with the divider on and bypassed.

// File: rtl/freq_lock_pkg.sv
package freq_lock_pkg;
  localparam int unsigned FL_INT_W    = 10;
  localparam int unsigned FL_TAP_W    = 5;
  localparam int unsigned FL_TAP_TOP  = 28;
  localparam int unsigned FL_DSEL_W   = 2;
  localparam int unsigned FL_NMUL_W   = 7;
  localparam int unsigned FL_BAND_W   = 2;
  localparam int unsigned FL_SYNC     = 2;
  localparam int unsigned FL_INIT     = 512;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'b00,
    STEP_DOWN = 2'b01,
    STEP_UP   = 2'b10,
    STEP_BOTH = 2'b11
  } step_e;
endpackage

// File: rtl/flk_ref_sync.sv
module flk_ref_sync #(
  parameter int unsigned STAGES = freq_lock_pkg::FL_SYNC
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_i,
  output logic rise_o
);
  // chain[0..STAGES-1] resynchronise, chain[STAGES] is the edge-detect history
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-1:0], ref_i};
  end

  assign rise_o = chain[STAGES-1] & ~chain[STAGES];

  // a detected rise is a single-cycle pulse (R3)
  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/flk_fb_div.sv
module flk_fb_div #(
  parameter int unsigned DSEL_W = freq_lock_pkg::FL_DSEL_W,
  parameter int unsigned NMUL_W = freq_lock_pkg::FL_NMUL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DSEL_W-1:0] div_sel_i,
  input  logic [NMUL_W-1:0] mult_n_i,
  output logic              pre_tick_o,
  output logic              dn_o
);
  localparam int unsigned PRE_MAX = 1 << ((1 << DSEL_W) - 1);
  localparam int unsigned PRE_CW  = (PRE_MAX > 1) ? $clog2(PRE_MAX) : 1;

  logic [PRE_CW-1:0] pre_cnt, pre_lim;
  logic [NMUL_W-1:0] post_cnt;
  logic              post_tick;

  always_comb pre_lim = PRE_CW'((32'd1 << div_sel_i) - 32'd1);

  assign pre_tick_o = (pre_cnt >= pre_lim);
  assign post_tick  = (post_cnt >= mult_n_i);
  assign dn_o       = pre_tick_o & post_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt  <= '0;
      post_cnt <= '0;
    end else begin
      pre_cnt <= pre_tick_o ? '0 : pre_cnt + 1'b1;
      if (pre_tick_o) post_cnt <= post_tick ? '0 : post_cnt + 1'b1;
    end
  end

  // pre-divider period is D: no back-to-back ticks unless D is 1 (R2)
  assert_pre_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pre_tick_o |=> (!pre_tick_o || div_sel_i == '0));
  // down events are separated unless the total ratio is 1 (R2)
  assert_dn_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dn_o |=> (!dn_o || (div_sel_i == '0 && mult_n_i == '0)));
endmodule

// File: rtl/flk_integ.sv
module flk_integ #(
  parameter int unsigned W    = freq_lock_pkg::FL_INT_W,
  parameter int unsigned INIT = freq_lock_pkg::FL_INIT
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         up_i,
  input  logic         dn_i,
  output logic [W-1:0] val_o
);
  import freq_lock_pkg::*;
  localparam logic [W-1:0] TOP = '1;

  step_e step;
  assign step = step_e'({up_i, dn_i});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) val_o <= W'(INIT);
    else begin
      case (step)
        STEP_UP:   if (val_o != TOP) val_o <= val_o + 1'b1;
        STEP_DOWN: if (val_o != '0)  val_o <= val_o - 1'b1;
        default:   val_o <= val_o;
      endcase
    end
  end

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (up_i && !dn_i && val_o == TOP) |=> val_o == TOP);
  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_i && !up_i && val_o == '0) |=> val_o == '0);
  assert_cancel_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (up_i && dn_i) |=> $stable(val_o));
  assert_up_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (up_i && !dn_i && val_o != TOP) |=> val_o == W'($past(val_o) + 1'b1));
endmodule

// File: rtl/flk_dither.sv
module flk_dither #(
  parameter int unsigned FW = freq_lock_pkg::FL_INT_W - freq_lock_pkg::FL_TAP_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [FW-1:0] frac_i,
  output logic          hi_o
);
  logic [FW-1:0] slot, slot_rev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot <= '0;
    else        slot <= slot + 1'b1;
  end

  // reversing the slot index spreads the k chosen slots evenly over the frame
  for (genvar b = 0; b < FW; b++) begin : g_rev
    assign slot_rev[b] = slot[FW-1-b];
  end

  assign hi_o = (slot_rev < frac_i);

  // a zero fraction never selects the upper tap (R7)
  assert_zero_frac_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (frac_i == '0) |-> !hi_o);
endmodule

// File: rtl/freq_lock_ctrl.sv
module freq_lock_ctrl #(
  parameter int unsigned INT_W   = freq_lock_pkg::FL_INT_W,
  parameter int unsigned TAP_W   = freq_lock_pkg::FL_TAP_W,
  parameter int unsigned TAP_TOP = freq_lock_pkg::FL_TAP_TOP,
  parameter int unsigned DSEL_W  = freq_lock_pkg::FL_DSEL_W,
  parameter int unsigned NMUL_W  = freq_lock_pkg::FL_NMUL_W,
  parameter int unsigned BAND_W  = freq_lock_pkg::FL_BAND_W,
  parameter int unsigned SYNC_N  = freq_lock_pkg::FL_SYNC,
  parameter int unsigned INIT    = freq_lock_pkg::FL_INIT
) (
  input  logic              clk_osc_i,
  input  logic              rst_ni,
  input  logic              ref_clk_i,
  input  logic [DSEL_W-1:0] div_sel_i,
  input  logic [NMUL_W-1:0] mult_n_i,
  input  logic              out_div_en_i,
  input  logic [BAND_W-1:0] range_sel_i,
  output logic [TAP_W-1:0]  tap_o,
  output logic [TAP_W-1:0]  mod_tap_o,
  output logic [INT_W-1:0]  integ_o,
  output logic              out_en_o,
  output logic [BAND_W-1:0] band_o
);
  localparam int unsigned FRAC_W = INT_W - TAP_W;
  localparam logic [TAP_W-1:0] TOP_TAP = TAP_W'(TAP_TOP);

  logic up_ev, dn_ev, pre_tick, hi_slot;
  logic [TAP_W-1:0]  coarse;
  logic [FRAC_W-1:0] frac;

  flk_ref_sync #(.STAGES(SYNC_N)) u_sync (
    .clk(clk_osc_i), .rst_n(rst_ni), .ref_i(ref_clk_i), .rise_o(up_ev));

  flk_fb_div #(.DSEL_W(DSEL_W), .NMUL_W(NMUL_W)) u_div (
    .clk(clk_osc_i), .rst_n(rst_ni), .div_sel_i(div_sel_i),
    .mult_n_i(mult_n_i), .pre_tick_o(pre_tick), .dn_o(dn_ev));

  flk_integ #(.W(INT_W), .INIT(INIT)) u_integ (
    .clk(clk_osc_i), .rst_n(rst_ni), .up_i(up_ev), .dn_i(dn_ev),
    .val_o(integ_o));

  assign coarse = integ_o[INT_W-1 -: TAP_W];
  assign frac   = integ_o[FRAC_W-1:0];

  flk_dither #(.FW(FRAC_W)) u_dith (
    .clk(clk_osc_i), .rst_n(rst_ni), .frac_i(frac), .hi_o(hi_slot));

  assign tap_o     = (coarse > TOP_TAP) ? TOP_TAP : coarse;
  assign mod_tap_o = (hi_slot && tap_o != TOP_TAP) ? tap_o + 1'b1 : tap_o;
  assign out_en_o  = out_div_en_i | pre_tick;

  always_ff @(posedge clk_osc_i or negedge rst_ni) begin
    if (!rst_ni) band_o <= '0;
    else         band_o <= range_sel_i;
  end

  assert_tap_range_R6: assert property (@(posedge clk_osc_i) disable iff (!rst_ni)
    tap_o <= TOP_TAP);
  assert_mod_adjacent_R7: assert property (@(posedge clk_osc_i) disable iff (!rst_ni)
    (mod_tap_o == tap_o) || (mod_tap_o == tap_o + 1'b1 && tap_o != TOP_TAP));
  assert_band_follow_R10: assert property (@(posedge clk_osc_i) disable iff (!rst_ni)
    1'b1 |=> band_o == $past(range_sel_i));
endmodule

// File: tb/freq_lock_ctrl_tb_top.sv
module freq_lock_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_q = 1'b0;
  logic [1:0] d_sel = 2'd1;
  logic [6:0] n_mul = 7'd0;
  logic odiv = 1'b0;
  logic [1:0] rsel = 2'd0;
  logic [4:0] tap, mtap;
  logic [9:0] integ;
  logic oen;
  logic [1:0] band;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  freq_lock_ctrl dut_i (
    .clk_osc_i(clk), .rst_ni(rst_n), .ref_clk_i(ref_q), .div_sel_i(d_sel),
    .mult_n_i(n_mul), .out_div_en_i(odiv), .range_sel_i(rsel),
    .tap_o(tap), .mod_tap_o(mtap), .integ_o(integ), .out_en_o(oen), .band_o(band));

  // cycle model built from the requirements
  int m_integ, m_cnt, m_band;
  bit r1, r2, r3;
  bit mism;
  string mmsg;

  function automatic int exp_tap(input int v);
    return ((v >> 5) > 28) ? 28 : (v >> 5);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_integ = 512; m_cnt = 0; m_band = 0; r1 = 0; r2 = 0; r3 = 0;
    end else begin
      bit up, dn;
      int per;
      per = (1 << d_sel) * (n_mul + 1);
      up = r2 && !r3;                          // R3: two sync stages then edge
      dn = (m_cnt == per - 1);                 // R2
      m_cnt = dn ? 0 : m_cnt + 1;
      if (up && !dn && m_integ < 1023) m_integ++;   // R4, R5
      if (dn && !up && m_integ > 0)    m_integ--;
      r3 = r2; r2 = r1; r1 = ref_q;
      m_band = rsel;                           // R10
    end
  end

  always @(negedge clk) begin
    if (rst_n && !mism) begin
      int et, eh, d;
      bit eo;
      et = exp_tap(m_integ);
      eh = (et == 28) ? 28 : et + 1;
      d  = 1 << d_sel;
      eo = odiv || ((m_cnt % d) == d - 1);
      if (integ != m_integ[9:0]) begin mism = 1; mmsg = $sformatf("integ act %0d exp %0d", integ, m_integ); end
      else if (tap != et) begin mism = 1; mmsg = $sformatf("tap act %0d exp %0d", tap, et); end
      else if (!(mtap == et || mtap == eh) || ((m_integ % 32) == 0 && mtap != et)) begin
        mism = 1; mmsg = $sformatf("mod_tap act %0d exp %0d or %0d", mtap, et, eh); end
      else if (oen != eo) begin mism = 1; mmsg = $sformatf("out_en act %0d exp %0d", oen, eo); end
      else if (band != m_band[1:0]) begin mism = 1; mmsg = $sformatf("band act %0d exp %0d", band, m_band); end
    end
  end

  task automatic check(input bit ok, input string req, input string detail);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s: %s", req, detail); end
  endtask

  task automatic close_phase(input string req);
    check(!mism, req, mmsg);
    mism = 0;
  endtask

  task automatic do_reset(input int ds, input int nm, input bit od);
    @(negedge clk);
    rst_n = 0; ref_q = 0; d_sel = 2'(ds); n_mul = 7'(nm); odiv = od; rsel = 0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1;
    mism = 0;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) ref_q = 1;
      @(negedge clk) ref_q = 0;
    end
  endtask

  task automatic mod_probe(input int k, input bit spacing);
    int cnt, last, gapbad;
    do_reset(3, 127, 0);
    pulses(k);
    repeat (4) @(negedge clk);
    check(integ == 10'(512 + k), "R3", $sformatf("integ act %0d exp %0d", integ, 512 + k));
    cnt = 0; last = -1; gapbad = 0;
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      if (mtap == 5'd17) begin
        cnt++;
        if (last >= 0 && (i - last) != 32 / k) gapbad++;
        last = i;
      end
    end
    check(cnt == k, "R7", $sformatf("upper-tap slots act %0d exp %0d", cnt, k));
    if (spacing) check(gapbad == 0, "R8", $sformatf("uneven gaps act %0d exp 0 for k %0d", gapbad, k));
    close_phase("R7");
  endtask

  initial begin
    int c;
    void'($urandom(32'd20240611));
    // R1: reset values
    rst_n = 0;
    repeat (2) @(negedge clk);
    check(integ == 10'd512, "R1", $sformatf("integ act %0d exp 512", integ));
    check(tap == 5'd16 && mtap == 5'd16, "R1", $sformatf("tap act %0d/%0d exp 16", tap, mtap));
    check(band == 2'd0, "R1", $sformatf("band act %0d exp 0", band));

    // R2: pure down rate, D=4 N=2 -> one step per 12 cycles
    do_reset(2, 2, 0);
    repeat (120) @(negedge clk);
    check(integ == 10'd502, "R2", $sformatf("integ act %0d exp 502", integ));
    close_phase("R2");

    // R9: enable rate with divider active and bypassed
    do_reset(2, 5, 0);
    c = 0;
    for (int i = 0; i < 16; i++) begin @(negedge clk); if (oen) c++; end
    check(c == 4, "R9", $sformatf("enable count act %0d exp 4", c));
    odiv = 1; c = 0;
    for (int i = 0; i < 16; i++) begin @(negedge clk); if (oen) c++; end
    check(c == 16, "R9", $sformatf("enable count act %0d exp 16", c));
    close_phase("R9");

    // R10: range select registered
    @(negedge clk) rsel = 2'd3;
    @(negedge clk);
    check(band == 2'd3, "R10", $sformatf("band act %0d exp 3", band));
    close_phase("R10");

    // R4: low saturation
    do_reset(0, 0, 0);
    repeat (530) @(negedge clk);
    check(integ == 10'd0 && tap == 5'd0 && mtap == 5'd0, "R4",
          $sformatf("integ/tap/mod act %0d/%0d/%0d exp 0/0/0", integ, tap, mtap));
    close_phase("R4");

    // R4, R6: high saturation and top-tap clamp
    do_reset(3, 127, 0);
    pulses(520);
    repeat (4) @(negedge clk);
    check(integ == 10'd1023, "R4", $sformatf("integ act %0d exp 1023", integ));
    check(tap == 5'd28 && mtap == 5'd28, "R6", $sformatf("tap/mod act %0d/%0d exp 28", tap, mtap));
    close_phase("R6");

    // R5: coincident up and down with divide-by-one feedback
    do_reset(0, 0, 0);
    pulses(100);
    repeat (4) @(negedge clk);
    close_phase("R5");

    // R7, R8: fractional mixing
    mod_probe(1, 1);
    mod_probe(8, 1);
    mod_probe(16, 1);
    mod_probe(13, 0);
    mod_probe(31, 0);

    // random trials: R2 R3 R5 R6 R9 R10 against the cycle model
    for (int t = 0; t < 30; t++) begin
      do_reset($urandom % 4, $urandom % 12, 1'($urandom % 2));
      for (int i = 0; i < 400; i++) begin
        @(negedge clk);
        if ($urandom % 3 == 0) ref_q = ~ref_q;
        if ($urandom % 50 == 0) rsel = 2'($urandom);
      end
      close_phase("R2 R3 R5 R6 R9 R10 random");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: act timeout exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule